// File: doc/BRIEF.md
# Programmable Even-Ratio Clock Divider with Line Gating

This block takes a fast reference clock and derives a module clock whose period is an even multiple of the reference period. A small register interface holds a 16-bit division value `n` and a pass-through bit. With pass-through clear, the output clock has a period of 2×(n+1) reference cycles at 50% duty. With pass-through set, the reference clock itself is driven out.

A second register holds one stop bit per module line. Each line leaves the block as a clock enable, which is high while that line may run. Changes to the ratio or to pass-through are deferred to the end of the current output period, and the pass-through select is retimed on the falling reference edge. As a result the output never carries a pulse shorter than half a reference period. Enable changes are applied only while the module clock is low.

The register port is a simple single-cycle write strobe with a combinational read. Software programs the ratio, then gates or ungates lines as its modules come and go.

Top module: `clkdiv_top`

## Requirements
- R1: With pass-through clear and division value n in register bits 15:0 at offset 0x00, `clk_out` is high for n+1 reference cycles and then low for n+1 reference cycles.
- R2: After reset, offsets 0x00 and 0x04 read zero, every bit of `line_en` is 1, and `clk_out` divides by 2 (one cycle high, one cycle low).
- R3: With the pass-through bit (bit 16 at offset 0x00) set, `clk_out` follows `clk_ref`, high after each rising reference edge and low after each falling one.
- R4: A new division value written during a high half leaves the length of that half unchanged; the next low half and the halves after it use the new value.
- R5: No pulse on `clk_out`, high or low, is shorter than half a reference period, including across entering and leaving pass-through.
- R6: A read of offset 0x00 returns the division value in bits 15:0 and pass-through in bit 16; bits 31:17 read zero even after all ones are written.
- R7: The gating register at offset 0x04 reads back all 32 written bits, and, once applied, bit k set drives `line_en[k]` to 0 while bit k clear drives it to 1.
- R8: `line_en` changes only while the module clock is low; a gating write made during a high half of `clk_out` is not visible until that half has ended.
- R9: Writes to any offset other than 0x00 and 0x04 change no register, and reads of such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock; also clocks the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one reference cycle per write |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| clk_out | output | 1 | Divided or passed-through module clock |
| line_en | output | 32 | Per-line clock enables, 1 = running |

## Verification
The divider is driven with a run of random division values from 0 to 12. Each value is measured by the length of its high and low runs, which separates an off-by-one in the 2×(n+1) rule from a duty-cycle error. A directed change of ratio, issued just after a rising output edge, shows whether the half in progress keeps its old length and the next one takes the new length. Entering and leaving pass-through is watched by a pulse-width monitor on every `clk_out` transition. Random gating words are written during a known high half, to show both the final enable values and that they wait for the low phase.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    localparam logic [31:0] OFS_DIVIDE = 32'h0000_0000;
    localparam logic [31:0] OFS_GATE   = 32'h0000_0004;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_DIVIDE = 2'd1,
        SEL_GATE   = 2'd2
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
        if (ofs == OFS_DIVIDE) begin
            return SEL_DIVIDE;
        end else if (ofs == OFS_GATE) begin
            return SEL_GATE;
        end
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned RATIO_W = 16,
    parameter int unsigned LINES   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               bypass_o,
    output logic [LINES-1:0]   gate_o
);

    localparam int unsigned BYP_BIT = RATIO_W;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               bypass;
        logic [LINES-1:0]   gate;
    } regs_t;

    regs_t    st_d, st_q;
    reg_sel_e sel;

    always_comb begin
        sel  = decode_ofs(32'(addr_i));
        st_d = st_q;
        if (wr_i) begin
            case (sel)
                SEL_DIVIDE: begin
                    st_d.ratio  = wdata_i[RATIO_W-1:0];
                    st_d.bypass = wdata_i[BYP_BIT];
                end
                SEL_GATE:   st_d.gate = wdata_i[LINES-1:0];
                default:    st_d = st_q;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_DIVIDE: begin
                rdata_o[RATIO_W-1:0] = st_q.ratio;
                rdata_o[BYP_BIT]     = st_q.bypass;
            end
            SEL_GATE:   rdata_o[LINES-1:0] = st_q.gate;
            default:    rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio_o  = st_q.ratio;
    assign bypass_o = st_q.bypass;
    assign gate_o   = st_q.gate;

    // R9: a write to an unmapped offset leaves every register as it was
    assert_unmapped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel == SEL_NONE) |=> (st_q == $past(st_q)));

    // R6: reserved upper bits of the divide register never read as one
    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_DIVIDE) |-> (rdata_o[DATA_W-1:BYP_BIT+1] == '0));

endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core #(
    parameter int unsigned RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_req_i,
    input  logic               bypass_req_i,
    output logic               phase_o,
    output logic               sel_o,
    output logic               clk_o
);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic               phase;
        logic [RATIO_W-1:0] ratio;
        logic               bypass;
    } core_t;

    core_t core_d, core_q;
    logic  sel_q;
    logic  half_end;
    logic  period_end;

    always_comb begin
        core_d     = core_q;
        half_end   = !core_q.bypass && (core_q.cnt == core_q.ratio);
        period_end = core_q.bypass || (half_end && core_q.phase);

        if (core_q.bypass) begin
            core_d.cnt   = '0;
            core_d.phase = 1'b0;
        end else if (half_end) begin
            core_d.cnt   = '0;
            core_d.phase = ~core_q.phase;
        end else begin
            core_d.cnt   = core_q.cnt + 1'b1;
        end

        if (period_end) begin
            core_d.ratio  = ratio_req_i;
            core_d.bypass = bypass_req_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    // pass-through select retimed on the falling edge so the mux only moves while both inputs are low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else begin
            sel_q <= core_q.bypass;
        end
    end

    assign clk_o   = sel_q ? clk : core_q.phase;
    assign phase_o = core_q.phase;
    assign sel_o   = sel_q;

    // R1: the half-period counter never runs past the active division value
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.cnt <= core_q.ratio);

    // R1: in divide mode the phase flips only after a full half of n+1 cycles
    assert_half_length_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(core_q.phase) && !$past(core_q.bypass))
            |-> ($past(core_q.cnt) == $past(core_q.ratio)));

    // R4: the active ratio moves only at the end of a full output period
    assert_ratio_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.ratio != $past(core_q.ratio))
            |-> ($past(core_q.bypass) || ($past(core_q.phase) && !core_q.phase)));

    // R5: the output mux switches only while the divided phase is low
    assert_sel_rise_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_q) |-> !core_q.phase);
    assert_sel_fall_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_q) |-> !core_q.phase);

endmodule

// File: rtl/clkdiv_gate.sv
`timescale 1ns/1ps
module clkdiv_gate #(
    parameter int unsigned LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] gate_i,
    input  logic             phase_i,
    input  logic             sel_i,
    output logic [LINES-1:0] en_o
);

    logic [LINES-1:0] en_d, en_q;
    logic             clk_low;

    always_comb begin
        clk_low = sel_i || !phase_i;
        en_d    = en_q;
        if (clk_low) begin
            en_d = ~gate_i;
        end
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[i] <= 1'b1;
            end else begin
                en_q[i] <= en_d[i];
            end
        end
    end

    assign en_o = en_q;

    // R8: an enable moves only while the module clock is in its low phase
    assert_en_low_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q != $past(en_q)) |-> (sel_i || !phase_i));

endmodule

// File: rtl/clkdiv_top.sv
`timescale 1ns/1ps
module clkdiv_top #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned RATIO_W = 16,
    parameter int unsigned LINES   = 32
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              clk_out,
    output logic [LINES-1:0]  line_en
);

    logic [RATIO_W-1:0] ratio_req;
    logic               bypass_req;
    logic [LINES-1:0]   gate_req;
    logic               phase;
    logic               sel;

    clkdiv_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RATIO_W(RATIO_W),
        .LINES  (LINES)
    ) u_regs (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .rdata_o (bus_rdata),
        .ratio_o (ratio_req),
        .bypass_o(bypass_req),
        .gate_o  (gate_req)
    );

    clkdiv_core #(
        .RATIO_W(RATIO_W)
    ) u_core (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .ratio_req_i (ratio_req),
        .bypass_req_i(bypass_req),
        .phase_o     (phase),
        .sel_o       (sel),
        .clk_o       (clk_out)
    );

    clkdiv_gate #(
        .LINES(LINES)
    ) u_gate (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .gate_i (gate_req),
        .phase_i(phase),
        .sel_i  (sel),
        .en_o   (line_en)
    );

endmodule

// File: tb/clkdiv_top_bench.sv
`timescale 1ns/1ps
module clkdiv_top_bench;

    logic        clk_ref = 1'b0;
    logic        rst_n   = 1'b0;
    logic        bus_wr  = 1'b0;
    logic [7:0]  bus_addr  = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        clk_out;
    logic [31:0] line_en;

    int n_cmp = 0;
    int n_bad = 0;
    int short_pulses = 0;
    bit mon_on = 1'b0;
    realtime last_edge = 0.0;

    always #2 clk_ref = ~clk_ref;

    clkdiv_top u_clkdiv_top (
        .clk_ref  (clk_ref),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .clk_out  (clk_out),
        .line_en  (line_en)
    );

    // pulse-width monitor for R5
    always @(clk_out) begin
        if (mon_on && ($realtime - last_edge) < 1.999) short_pulses++;
        last_edge = $realtime;
        mon_on    = rst_n;
    end

    function automatic int exp_half(input int n);
        return n + 1;
    endfunction

    function automatic logic [31:0] exp_div_word(input logic byp, input logic [15:0] n);
        return {15'd0, byp, n};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic samp(output logic v);
        @(posedge clk_ref);
        #1;
        v = clk_out;
    endtask

    // called one time unit after a rising edge; returns clk_out after the commit edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic v);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk_ref);
        #1;
        v      = clk_out;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic sync_rise();
        logic p, v;
        samp(p);
        for (int g = 0; g < 200000; g++) begin
            samp(v);
            if (!p && v) break;
            p = v;
        end
    endtask

    task automatic measure(output int hi, output int lo);
        logic v;
        sync_rise();
        hi = 1;
        samp(v);
        while (v) begin hi++; samp(v); end
        lo = 1;
        samp(v);
        while (!v) begin lo++; samp(v); end
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        v;
        int          hi, lo;
        logic [31:0] g_old, g_new;
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk_ref);
        #1;
        rst_n = 1'b1;
        @(posedge clk_ref);
        #1;

        // R2: reset state
        rd(8'h00, d); chk("R2 divide reg", d, 32'd0);
        rd(8'h04, d); chk("R2 gate reg", d, 32'd0);
        chk("R2 line_en", line_en, 32'hFFFF_FFFF);
        measure(hi, lo);
        chk("R2 high", hi, exp_half(0));
        chk("R2 low", lo, exp_half(0));

        // R1: random division values
        for (int i = 0; i < 10; i++) begin
            int n;
            n = $urandom_range(0, 12);
            wr(8'h00, exp_div_word(1'b0, 16'(n)), v);
            measure(hi, lo);
            measure(hi, lo);
            chk("R1 high", hi, exp_half(n));
            chk("R1 low", lo, exp_half(n));
            rd(8'h00, d); chk("R6 readback", d, exp_div_word(1'b0, 16'(n)));
        end

        // R4: change ratio during a high half
        wr(8'h00, exp_div_word(1'b0, 16'd4), v);
        measure(hi, lo);
        sync_rise();
        hi = 1;
        wr(8'h00, exp_div_word(1'b0, 16'd7), v);
        while (v) begin hi++; samp(v); end
        lo = 1;
        samp(v);
        while (!v) begin lo++; samp(v); end
        chk("R4 old high kept", hi, exp_half(4));
        chk("R4 new low", lo, exp_half(7));
        measure(hi, lo);
        chk("R4 new high", hi, exp_half(7));

        // R8 / R7: gating written during a high half
        wr(8'h00, exp_div_word(1'b0, 16'd5), v);
        measure(hi, lo);
        measure(hi, lo);
        g_old = ~line_en;
        for (int i = 0; i < 4; i++) begin
            g_new = $urandom();
            sync_rise();
            wr(8'h04, g_new, v);
            while (v) begin
                chk("R8 held during high", line_en, ~g_old);
                samp(v);
            end
            samp(v);
            chk("R7 enables applied", line_en, ~g_new);
            rd(8'h04, d); chk("R7 gate readback", d, g_new);
            g_old = g_new;
        end
        wr(8'h04, 32'h8000_0001, v);
        repeat (16) samp(v);
        chk("R7 edge bits", line_en, 32'h7FFF_FFFE);

        // R9: unmapped offsets
        wr(8'h08, 32'hFFFF_FFFF, v);
        wr(8'h40, 32'h1234_5678, v);
        rd(8'h08, d); chk("R9 unmapped read", d, 32'd0);
        rd(8'h00, d); chk("R9 divide untouched", d, exp_div_word(1'b0, 16'd5));
        rd(8'h04, d); chk("R9 gate untouched", d, 32'h8000_0001);

        // R3 / R5: enter pass-through
        wr(8'h00, exp_div_word(1'b1, 16'd3), v);
        repeat (20) samp(v);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk_ref); #1;
            chk("R3 follows ref high", clk_out, 1'b1);
            @(negedge clk_ref); #1;
            chk("R3 follows ref low", clk_out, 1'b0);
        end
        #1;

        // R6: reserved bits
        @(posedge clk_ref); #1;
        wr(8'h00, 32'hFFFF_FFFF, v);
        rd(8'h00, d); chk("R6 reserved zero", d, 32'h0001_FFFF);

        // R5 / R1: leave pass-through
        wr(8'h00, exp_div_word(1'b0, 16'd2), v);
        measure(hi, lo);
        measure(hi, lo);
        chk("R1 after bypass high", hi, exp_half(2));
        chk("R1 after bypass low", lo, exp_half(2));
        wr(8'h00, exp_div_word(1'b1, 16'd0), v);
        repeat (10) samp(v);
        wr(8'h00, exp_div_word(1'b0, 16'd0), v);
        measure(hi, lo);
        chk("R1 div2 after bypass", hi, exp_half(0));

        chk("R5 short pulses", short_pulses, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule